// File: doc/BRIEF.md
# Distributed Bus Arbitration Agent

This block is one agent's share of a distributed, priority-based arbitration scheme for a shared parallel system bus. No central arbiter exists: every agent on the bus runs an identical copy, and the agents settle ownership among themselves. They do it through an open-drain, active-low request line and a 6-bit group of open-drain arbitration lines. The block drives pull-down enables and reads back the resolved line levels. The physical wiring performs the wired-AND.

The same arbitration lines serve two purposes. While the system is held in reset, a central services module places values on them, and the agent captures two of those values on successive rising edges of its per-slot latch strobe. The first value becomes the card's slot identity. The second becomes its arbitration identity.

In normal operation a local requester raises `req_i`. The agent then joins the next arbitration round and competes bit by bit, most significant bit first, backing off as soon as it sees that it has lost. It reports the result as a grant or a one-cycle loss pulse. While it holds the bus, a timeout or bus error indication makes it drop the bus and pulse an error flag to the local side.

Top module: `bus_arb_agent`

## Requirements
- R1: While `rst_ni` is low, `grant_o`, `lost_o`, `err_o`, `breq_pull_o` and `arb_pull_o` are 0, and `slot_id_o` and `arb_id_o` are 0.
- R2: The reset phase lasts while `bus_rst_i` or `rst_pending_i` is high. Each new reset phase restarts the capture sequence. In that phase, the first rising edge of `id_strobe_i` loads `slot_id_o` and the second loads `arb_id_o`, each with the bitwise inverse of `arb_line_i` (a line read low is a 1 bit). A strobe held high for several cycles counts once. Later strobes in the same reset phase, and every strobe outside the reset phase, leave both identities unchanged.
- R3: From the first clock edge that samples the reset phase, `breq_pull_o`, `arb_pull_o` and `grant_o` are 0 until the phase ends, even if the agent held the bus before.
- R4: An idle agent with `req_i` high starts to pull the request line (`breq_pull_o` = 1) one cycle after an edge that samples `breq_line_i` high. If it samples the line low, it stays off the line and waits for the line to go high.
- R5: An agent pulling the request line starts its round on the edge that samples `breq_line_i` falling. For the next 6 cycles it drives `arb_pull_o` (1 = pull that line low) with the bits of its arbitration identity that are 1, examining one line per cycle from bit 5 down to bit 0. When its own bit is 0 and the examined line reads low, it stops pulling every lower bit for the rest of the round.
- R6: If the resolved value at the end of the round equals its identity, the agent wins: `grant_o` rises seven cycles after `breq_pull_o` rises, and the highest identity among the agents in the round wins. In the final round cycle the winner still drives its whole identity.
- R7: A losing agent pulses `lost_o` for one cycle and releases the request line and the arbitration lines on that same cycle. It rejoins only after the request line has returned high.
- R8: The owner keeps pulling the request line while `grant_o` is high. This blocks new rounds. It drops `grant_o` and `breq_pull_o` one cycle after it samples `req_i` low.
- R9: If `timeout_i` or `bus_err_i` is sampled high while `grant_o` is high, then on the next cycle `grant_o`, `breq_pull_o` and `arb_pull_o` are 0 and `err_o` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous local reset, active low |
| bus_rst_i | input | 1 | System bus reset indication, synchronous, active high |
| rst_pending_i | input | 1 | System reset sequence still running, active high |
| id_strobe_i | input | 1 | Per-slot identity latch strobe |
| arb_line_i | input | 6 | Resolved levels of the shared arbitration lines (low = pulled) |
| arb_pull_o | output | 6 | Pull-down enables for the arbitration lines |
| breq_line_i | input | 1 | Resolved level of the shared request line (low = requested) |
| breq_pull_o | output | 1 | Pull-down enable for the request line |
| timeout_i | input | 1 | Bus cycle timeout from the central module |
| bus_err_i | input | 1 | Bus error indication |
| req_i | input | 1 | Local request for bus ownership |
| grant_o | output | 1 | Agent owns the bus |
| lost_o | output | 1 | One-cycle pulse: round lost |
| err_o | output | 1 | One-cycle pulse: ownership aborted by timeout or bus error |
| slot_id_o | output | 6 | Captured slot identity |
| arb_id_o | output | 6 | Captured arbitration identity |

## Verification
The bench builds the agent with the default 6-bit identity width. That gives six-cycle rounds and every bit position where a back-off can happen. Two behavioural competitor agents share the modelled wired lines with it. With them, the bench can pit the agent against higher and lower identities, including pairs such as 011111 against 100000 where only an early back-off lets the correct agent win. It can also run three-way rounds, late joiners that must wait, and a bus reset that arrives while the agent owns the bus.

// File: rtl/abt_pkg.sv
package abt_pkg;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_IDLE,
    ST_JOIN,
    ST_ARB,
    ST_OWN
  } agent_state_e;

endpackage

// File: rtl/abt_id_capture.sv
module abt_id_capture #(
  parameter int ID_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            strobe_i,
  input  logic [ID_W-1:0] bus_val_i,
  output logic [ID_W-1:0] slot_id_o,
  output logic [ID_W-1:0] arb_id_o
);

  logic       load_q, strobe_q;
  logic [1:0] seq_q, seq_base;
  logic       strobe_rise;

  assign strobe_rise = strobe_i & ~strobe_q;
  // a fresh reset phase restarts the capture order
  assign seq_base    = (load_i & ~load_q) ? 2'd0 : seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q    <= 1'b0;
      strobe_q  <= 1'b0;
      seq_q     <= 2'd0;
      slot_id_o <= '0;
      arb_id_o  <= '0;
    end else begin
      load_q   <= load_i;
      strobe_q <= strobe_i;
      seq_q    <= seq_base;
      if (load_i && strobe_rise) begin
        unique case (seq_base)
          2'd0: begin
            slot_id_o <= bus_val_i;
            seq_q     <= 2'd1;
          end
          2'd1: begin
            arb_id_o <= bus_val_i;
            seq_q    <= 2'd2;
          end
          default: seq_q <= seq_base;
        endcase
      end
    end
  end

  a_r2_ids_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(slot_id_o) && $stable(arb_id_o)));

endmodule

// File: rtl/abt_prio_resolver.sv
module abt_prio_resolver #(
  parameter int ID_W   = 6,
  parameter int STEP_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            clear_i,
  input  logic [ID_W-1:0] own_id_i,
  input  logic [ID_W-1:0] res_i,
  output logic [ID_W-1:0] pull_o,
  output logic            done_o,
  output logic            win_o
);

  localparam logic [STEP_W-1:0] TOP_STEP = STEP_W'(ID_W - 1);

  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic [ID_W-1:0]   keep_q;
  logic [ID_W-1:0]   below_w;
  logic              beaten_w;

  assign below_w  = (ID_W'(1) << step_q) - ID_W'(1);
  assign beaten_w = !own_id_i[step_q] && res_i[step_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      keep_q <= '1;
    end else if (clear_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      step_q <= TOP_STEP;
      keep_q <= '1;
    end else if (busy_q) begin
      if (beaten_w) keep_q <= keep_q & ~below_w;
      if (step_q == '0) busy_q <= 1'b0;
      else              step_q <= step_q - 1'b1;
    end
  end

  assign pull_o = busy_q ? (own_id_i & keep_q) : '0;
  assign done_o = busy_q && (step_q == '0);
  assign win_o  = (res_i == own_id_i);

  a_r5_keep_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && !clear_i) |=> ((keep_q & ~$past(keep_q)) == '0));

endmodule

// File: rtl/bus_arb_agent.sv
module bus_arb_agent
  import abt_pkg::*;
#(
  parameter int ID_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_rst_i,
  input  logic            rst_pending_i,
  input  logic            id_strobe_i,
  input  logic [ID_W-1:0] arb_line_i,
  output logic [ID_W-1:0] arb_pull_o,
  input  logic            breq_line_i,
  output logic            breq_pull_o,
  input  logic            timeout_i,
  input  logic            bus_err_i,
  input  logic            req_i,
  output logic            grant_o,
  output logic            lost_o,
  output logic            err_o,
  output logic [ID_W-1:0] slot_id_o,
  output logic [ID_W-1:0] arb_id_o
);

  localparam int STEP_W = (ID_W > 1) ? $clog2(ID_W) : 1;

  agent_state_e    state_q, state_d;
  logic            breq_q, lost_q, err_q;
  logic            load_w, fell_w, start_w;
  logic            rs_done, rs_win;
  logic [ID_W-1:0] res_w;

  assign load_w  = bus_rst_i | rst_pending_i;
  assign res_w   = ~arb_line_i;
  assign fell_w  = breq_q & ~breq_line_i;
  assign start_w = (state_q == ST_JOIN) && fell_w && !load_w;

  abt_id_capture #(.ID_W(ID_W)) u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_w),
    .strobe_i (id_strobe_i),
    .bus_val_i(res_w),
    .slot_id_o(slot_id_o),
    .arb_id_o (arb_id_o)
  );

  abt_prio_resolver #(.ID_W(ID_W), .STEP_W(STEP_W)) u_resolver (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .clear_i (load_w),
    .own_id_i(arb_id_o),
    .res_i   (res_w),
    .pull_o  (arb_pull_o),
    .done_o  (rs_done),
    .win_o   (rs_win)
  );

  always_comb begin
    state_d = state_q;
    if (load_w) begin
      state_d = ST_LOAD;
    end else begin
      unique case (state_q)
        ST_LOAD: state_d = ST_IDLE;
        ST_IDLE: if (req_i && breq_line_i) state_d = ST_JOIN;
        ST_JOIN: if (fell_w) state_d = ST_ARB;
        ST_ARB:  if (rs_done) state_d = rs_win ? ST_OWN : ST_IDLE;
        ST_OWN:  if (timeout_i || bus_err_i || !req_i) state_d = ST_IDLE;
        default: state_d = ST_LOAD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      breq_q  <= 1'b1;
      lost_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      breq_q  <= breq_line_i;
      lost_q  <= (state_q == ST_ARB) && rs_done && !rs_win && !load_w;
      err_q   <= (state_q == ST_OWN) && (timeout_i || bus_err_i) && !load_w;
    end
  end

  assign grant_o     = (state_q == ST_OWN);
  assign breq_pull_o = (state_q == ST_JOIN) || (state_q == ST_ARB) || (state_q == ST_OWN);
  assign lost_o      = lost_q;
  assign err_o       = err_q;

  a_r3_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_w |=> (!breq_pull_o && !grant_o && arb_pull_o == '0));

  a_r4_wait_busy_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!breq_pull_o && !breq_line_i) |=> !breq_pull_o);

  a_r5_no_arb_drive_off_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !breq_pull_o |-> (arb_pull_o == '0));

  a_r6_winner_full_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> ($past(arb_pull_o) == arb_id_o));

  a_r7_lost_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> (!breq_pull_o && !grant_o && arb_pull_o == '0));

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !req_i && !load_w) |=> (!grant_o && !breq_pull_o));

  a_r9_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && (timeout_i || bus_err_i) && !load_w) |=> (!grant_o && !breq_pull_o && err_o));

  a_r9_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

endmodule

// File: tb/bus_arb_agent_tb.sv
`timescale 1ns/1ps
module bus_arb_agent_tb;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst = 1'b0, rst_pend = 1'b0, strobe = 1'b0;
  logic tmo = 1'b0, berr = 1'b0, req = 1'b0;
  logic [W-1:0] csm = '0;
  logic [W-1:0] dut_arb, slot_o, arb_o;
  logic dut_breq, grant, lost, err;
  logic [W-1:0] arb_line;
  logic breq_line;

  int n_tests = 0, n_fail = 0;
  logic [W-1:0] dut_id = '0;

  // behavioural competitors
  int           cmode [2];
  int           ccnt  [2];
  logic [W-1:0] cid   [2];
  logic [W-1:0] ckeep [2];
  logic         creq  [2];
  logic [1:0]   c_breq;
  logic [W-1:0] c_arb [2];

  // reference model state
  int   m_mode, m_cnt;
  logic m_lost, m_err, line_q;

  always #2.5 clk = ~clk;

  assign breq_line = ~(dut_breq | c_breq[0] | c_breq[1]);
  assign arb_line  = ~(dut_arb | c_arb[0] | c_arb[1] | csm);

  bus_arb_agent #(.ID_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_i(bus_rst), .rst_pending_i(rst_pend),
    .id_strobe_i(strobe), .arb_line_i(arb_line), .arb_pull_o(dut_arb),
    .breq_line_i(breq_line), .breq_pull_o(dut_breq), .timeout_i(tmo),
    .bus_err_i(berr), .req_i(req), .grant_o(grant), .lost_o(lost), .err_o(err),
    .slot_id_o(slot_o), .arb_id_o(arb_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      c_breq[c] = (cmode[c] >= 1);
      c_arb[c]  = (cmode[c] == 2) ? (cid[c] & ckeep[c]) : '0;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        cmode[c] <= 0; ccnt[c] <= 0; ckeep[c] <= '1;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (bus_rst || rst_pend) cmode[c] <= 0;
        else case (cmode[c])
          0: if (creq[c] && breq_line) cmode[c] <= 1;
          1: if (line_q && !breq_line) begin
               cmode[c] <= 2; ccnt[c] <= W - 1; ckeep[c] <= '1;
             end
          2: begin
               if (!cid[c][ccnt[c]] && !arb_line[ccnt[c]])
                 ckeep[c] <= ckeep[c] & ~W'((1 << ccnt[c]) - 1);
               if (ccnt[c] == 0) cmode[c] <= ((~arb_line) == cid[c]) ? 3 : 0;
               else ccnt[c] <= ccnt[c] - 1;
             end
          default: if (!creq[c]) cmode[c] <= 0;
        endcase
      end
    end
  end

  // reference: highest identity among the round's agents wins, fixed latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 0; m_cnt <= 0; m_lost <= 1'b0; m_err <= 1'b0; line_q <= 1'b1;
    end else begin
      line_q <= breq_line;
      m_lost <= 1'b0;
      m_err  <= 1'b0;
      if (bus_rst || rst_pend) m_mode <= 0;
      else case (m_mode)
        0: m_mode <= 1;
        1: if (req && breq_line) m_mode <= 2;
        2: if (line_q && !breq_line) begin m_mode <= 3; m_cnt <= W - 1; end
        3: if (m_cnt == 0) begin
             bit beaten;
             beaten = 1'b0;
             for (int c = 0; c < 2; c++)
               if (cmode[c] == 2 && ccnt[c] == 0 && cid[c] > dut_id) beaten = 1'b1;
             if (beaten) begin m_mode <= 1; m_lost <= 1'b1; end
             else m_mode <= 4;
           end else m_cnt <= m_cnt - 1;
        default: if (tmo || berr) begin m_mode <= 1; m_err <= 1'b1; end
                 else if (!req) m_mode <= 1;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(grant == (m_mode == 4), "R6/R8 grant", grant, m_mode == 4);
      chk(dut_breq == (m_mode >= 2), "R4/R7 request pull", dut_breq, m_mode >= 2);
      chk(lost == m_lost, "R7 lost pulse", lost, m_lost);
      chk(err == m_err, "R9 error pulse", err, m_err);
      if (m_mode <= 1) chk(dut_arb == '0, "R5 arb idle", dut_arb, 0);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_ids(input logic [W-1:0] slot, input logic [W-1:0] aid, input int hold);
    tick();
    bus_rst = 1'b1; rst_pend = 1'b1; csm = slot; dut_id = aid;
    tick();
    chk(!dut_breq && !grant && dut_arb == '0, "R3 quiet in reset", dut_breq, 0);
    strobe = 1'b1; tick(hold); strobe = 1'b0;
    csm = aid; tick();
    strobe = 1'b1; tick(); strobe = 1'b0;
    csm = 6'h3F; tick(); strobe = 1'b1; tick(); strobe = 1'b0; // third strobe ignored
    bus_rst = 1'b0; csm = '0; tick();
    rst_pend = 1'b0; tick(2);
    chk(slot_o == slot, "R2 slot capture", slot_o, slot);
    chk(arb_o == aid, "R2 arb capture", arb_o, aid);
  endtask

  initial begin
    #250000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin creq[c] = 1'b0; cid[c] = '0; end
    tick(3);
    chk(!grant && !lost && !err && !dut_breq && dut_arb == '0, "R1 outputs", grant, 0);
    chk(slot_o == '0 && arb_o == '0, "R1 ids", arb_o, 0);
    rst_n = 1'b1;

    load_ids(6'h05, 6'h2A, 1);

    // solo request
    req = 1'b1; tick(12);
    chk(grant, "R6 solo grant", grant, 1);
    req = 1'b0; tick(3);

    // lower competitor, then it takes over on release
    cid[0] = 6'h15; req = 1'b1; creq[0] = 1'b1; tick(12);
    chk(grant && cmode[0] == 0, "R6 beats lower", grant, 1);
    req = 1'b0; tick(12);
    chk(cmode[0] == 3, "R8 release lets waiter in", cmode[0], 3);
    creq[0] = 1'b0; tick(3);

    // back-off: 011111 against 100000
    load_ids(6'h09, 6'h1F, 1);
    cid[0] = 6'h20; req = 1'b1; creq[0] = 1'b1; tick(2);
    chk(dut_arb == 6'h1F, "R5 full drive first step", dut_arb, 6'h1F);
    tick();
    chk(dut_arb == 6'h00, "R5 back-off below lost bit", dut_arb, 0);
    tick(10);
    chk(!grant && !dut_breq, "R7 waits while line held", dut_breq, 0);
    creq[0] = 1'b0; tick(12);
    chk(grant, "R7 rejoins after release", grant, 1);
    req = 1'b0; tick(3);

    // three-way round
    load_ids(6'h11, 6'h30, 1);
    cid[0] = 6'h2F; cid[1] = 6'h0F;
    req = 1'b1; creq[0] = 1'b1; creq[1] = 1'b1; tick(12);
    chk(grant, "R6 three-way win", grant, 1);
    req = 1'b0; tick(12);
    chk(cmode[0] == 3 && cmode[1] == 0, "R6 next highest wins", cmode[0], 3);
    creq[0] = 1'b0; tick(12); creq[1] = 1'b0; tick(12);

    // timeout with release, bus error with request kept
    req = 1'b1; tick(12);
    tmo = 1'b1; req = 1'b0; tick(); tmo = 1'b0;
    chk(!grant && err, "R9 timeout abort", err, 1);
    tick(4);
    req = 1'b1; tick(12);
    berr = 1'b1; tick(); berr = 1'b0;
    chk(!grant && err && dut_arb == '0, "R9 bus error abort", err, 1);
    tick(12);
    chk(grant, "R9 rejoin after abort", grant, 1);

    // bus reset while owning, strobe held high for several cycles
    load_ids(6'h0C, 6'h33, 3);
    tick(12);
    chk(grant, "R3 own again after reset", grant, 1);
    req = 1'b0; tick(3);

    // strobe outside reset ignored
    csm = 6'h3F; strobe = 1'b1; tick(); strobe = 1'b0; tick(); csm = '0; tick();
    chk(slot_o == 6'h0C && arb_o == 6'h33, "R2 strobe outside reset", arb_o, 6'h33);

    tick(5);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule